// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block is the execute stage for a family of three-byte loop instructions. Each one selects a counter register and may step it down by one, step it up by one, or leave it as it is. The block then tests the resulting value against zero and decides whether to branch. A control byte (the postbyte) carries four things: the operation, the branch sense, the top bit of a 9-bit signed displacement, and the register select. The third byte holds the low eight bits of that displacement.

The surrounding core supplies the opcode, the postbyte, the displacement byte, the address of the instruction and the current counter registers. These are two 8-bit accumulators, the 16-bit pair formed from them, two 16-bit index registers and the stack pointer. The block computes its result in one combinational pass and registers it. One cycle after issue it presents:

- the next program counter,
- a taken flag,
- the updated counter value,
- one write strobe per architectural register,
- an illegal-code flag.

It also drives a constant cycle-count figure for the instruction. It never touches condition codes.

Top module: `loop_branch_unit`

## Requirements
- R1: Results appear on the outputs on the clock edge after a cycle with `in_valid` high, with `out_valid` high. After a cycle with `in_valid` low, `out_valid`, `taken`, `illegal` and every write strobe are 0. Reset clears all registered outputs to 0.
- R2: On a taken branch, `next_pc` equals the instruction address + 3 + the sign-extended 9-bit displacement {postbyte[4], offset byte}, modulo 2^16. The reachable span is -256 to +255 from the following instruction.
- R3: On a branch that is not taken, `next_pc` equals the instruction address + 3, modulo 2^16.
- R4: Postbyte bit 5 sets the sense. With 0 the branch is taken when the resulting counter is zero. With 1 it is taken when the counter is non-zero.
- R5: Postbyte bits 7:6 = 01 test the counter without changing it. No write strobe is raised, and `cnt_value` equals the current register value.
- R6: Postbyte bits 7:6 = 00 decrement the counter and 10 increment it. The zero test uses the value after the step, and that value is written back.
- R7: Postbyte bits 2:0 select the counter: 000 A, 001 B, 100 D, 101 X, 110 Y, 111 SP. Only the selected register's strobe rises. Postbyte bit 3 has no effect.
- R8: A and B wrap modulo 256, and D, X, Y and SP wrap modulo 65536. An 8-bit result sits in the low byte of `cnt_value` with a zero high byte. D is {A, B}: a D update raises both `wr_a` and `wr_b`, with A taking `cnt_value[15:8]` and B taking `cnt_value[7:0]`.
- R9: Any of the following raises `illegal`, keeps every strobe and `taken` at 0, and gives `next_pc` = address + 3:
  - postbyte bits 7:6 = 11;
  - register code 010 or 011;
  - an opcode other than 0x04.
- R10: The `cycles` output always reads 3, for taken and not-taken branches alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction issued this cycle |
| opcode | input | 8 | First instruction byte |
| postbyte | input | 8 | Operation, sense, offset sign, register select |
| offset_lo | input | 8 | Low eight bits of the displacement |
| pc_in | input | 16 | Address of the instruction |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| sp_in | input | 16 | Stack pointer |
| out_valid | output | 1 | Registered result valid |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Branch taken |
| cnt_value | output | 16 | Counter value after the operation |
| wr_a | output | 1 | Write strobe for A |
| wr_b | output | 1 | Write strobe for B |
| wr_x | output | 1 | Write strobe for X |
| wr_y | output | 1 | Write strobe for Y |
| wr_sp | output | 1 | Write strobe for SP |
| illegal | output | 1 | Reserved or foreign code seen |
| cycles | output | 4 | Cycle count of the instruction (always 3) |

## Verification
The bench uses the default parameters: 16-bit program counter, 8-bit accumulators and 16-bit index registers. At these widths the wrap points are ordinary values the bench can drive directly. For the 8-bit counters these are 0x00 and 0xFF, and for the 16-bit counters they are 0x0000 and 0xFFFF. The bench biases its random counter values towards those points. It also drives program counters near both ends of the address space together with offsets at -256 and +255, so the modulo-2^16 target arithmetic is exercised at both ends.

// File: rtl/loop_branch_unit.sv
module loop_branch_unit #(
  parameter int PCW = 16,
  parameter int AW = 8,
  parameter int IW = 16,
  parameter int CW = (2 * AW > IW) ? 2 * AW : IW,
  parameter logic [7:0] OPCODE = 8'h04,
  parameter int CYCLES = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     opcode,
  input  logic [7:0]     postbyte,
  input  logic [7:0]     offset_lo,
  input  logic [PCW-1:0] pc_in,
  input  logic [AW-1:0]  acc_a,
  input  logic [AW-1:0]  acc_b,
  input  logic [IW-1:0]  idx_x,
  input  logic [IW-1:0]  idx_y,
  input  logic [IW-1:0]  sp_in,
  output logic           out_valid,
  output logic [PCW-1:0] next_pc,
  output logic           taken,
  output logic [CW-1:0]  cnt_value,
  output logic           wr_a,
  output logic           wr_b,
  output logic           wr_x,
  output logic           wr_y,
  output logic           wr_sp,
  output logic           illegal,
  output logic [3:0]     cycles
);

  localparam logic [1:0] OP_DEC  = 2'b00;
  localparam logic [1:0] OP_TEST = 2'b01;
  localparam logic [1:0] OP_INC  = 2'b10;
  localparam logic [1:0] OP_RSV  = 2'b11;

  localparam logic [2:0] SEL_A  = 3'b000;
  localparam logic [2:0] SEL_B  = 3'b001;
  localparam logic [2:0] SEL_D  = 3'b100;
  localparam logic [2:0] SEL_X  = 3'b101;
  localparam logic [2:0] SEL_Y  = 3'b110;
  localparam logic [2:0] SEL_SP = 3'b111;

  localparam logic [CW-1:0] M_ACC  = {CW{1'b1}} >> (CW - AW);
  localparam logic [CW-1:0] M_PAIR = {CW{1'b1}} >> (CW - 2 * AW);
  localparam logic [CW-1:0] M_IDX  = {CW{1'b1}} >> (CW - IW);

  logic [1:0] op;
  logic [2:0] sel;
  logic       sense;
  logic       legal;
  logic       modify;
  logic [CW-1:0] cur, mask, stepped, nxt;
  logic [PCW-1:0] disp, seq_pc, tgt_pc;
  logic       cond;

  assign op    = postbyte[7:6];
  assign sense = postbyte[5];
  assign sel   = postbyte[2:0];

  assign legal  = (opcode == OPCODE) && (op != OP_RSV) &&
                  (sel != 3'b010) && (sel != 3'b011);
  assign modify = legal && (op != OP_TEST);

  always_comb begin
    cur  = '0;
    mask = M_IDX;
    unique case (sel)
      SEL_A:   begin cur = CW'(acc_a);          mask = M_ACC;  end
      SEL_B:   begin cur = CW'(acc_b);          mask = M_ACC;  end
      SEL_D:   begin cur = CW'({acc_a, acc_b}); mask = M_PAIR; end
      SEL_X:   cur = CW'(idx_x);
      SEL_Y:   cur = CW'(idx_y);
      SEL_SP:  cur = CW'(sp_in);
      default: cur = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_DEC:  stepped = cur - CW'(1);
      OP_INC:  stepped = cur + CW'(1);
      default: stepped = cur;
    endcase
  end

  assign nxt    = stepped & mask;
  assign cond   = sense ? (nxt != '0) : (nxt == '0);
  assign disp   = {{(PCW-8){postbyte[4]}}, offset_lo};
  assign seq_pc = pc_in + PCW'(3);
  assign tgt_pc = seq_pc + disp;
  assign cycles = 4'(CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cnt_value <= '0;
      wr_a      <= 1'b0;
      wr_b      <= 1'b0;
      wr_x      <= 1'b0;
      wr_y      <= 1'b0;
      wr_sp     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      next_pc   <= (legal && cond) ? tgt_pc : seq_pc;
      cnt_value <= nxt;
      taken     <= in_valid && legal && cond;
      illegal   <= in_valid && !legal;
      wr_a      <= in_valid && modify && (sel == SEL_A || sel == SEL_D);
      wr_b      <= in_valid && modify && (sel == SEL_B || sel == SEL_D);
      wr_x      <= in_valid && modify && (sel == SEL_X);
      wr_y      <= in_valid && modify && (sel == SEL_Y);
      wr_sp     <= in_valid && modify && (sel == SEL_SP);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(out_valid || taken || illegal || wr_a || wr_b || wr_x || wr_y || wr_sp)); // R1
  AST_FALLTHRU_PC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taken || next_pc == $past(pc_in) + PCW'(3))); // R3
  AST_SENSE_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !postbyte[5]) |=> (!taken || cnt_value == '0)); // R4
  AST_SENSE_NE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && postbyte[5]) |=> (!taken || cnt_value != '0)); // R4
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && postbyte[7:6] == OP_TEST) |=> !(wr_a || wr_b || wr_x || wr_y || wr_sp)); // R5
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_a | wr_b, wr_x, wr_y, wr_sp})); // R7
  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(taken || wr_a || wr_b || wr_x || wr_y || wr_sp)); // R9
  AST_FIXED_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cycles)); // R10

endmodule

// File: tb/test_loop_branch_unit.sv
module test_loop_branch_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] opcode = '0, postbyte = '0, offset_lo = '0;
  logic [15:0] pc_in = '0;
  logic [7:0] acc_a = '0, acc_b = '0;
  logic [15:0] idx_x = '0, idx_y = '0, sp_in = '0;
  logic out_valid, taken, wr_a, wr_b, wr_x, wr_y, wr_sp, illegal;
  logic [15:0] next_pc, cnt_value;
  logic [3:0] cycles;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loop_branch_unit i_loop_branch_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .postbyte(postbyte), .offset_lo(offset_lo), .pc_in(pc_in),
    .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y), .sp_in(sp_in),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .cnt_value(cnt_value),
    .wr_a(wr_a), .wr_b(wr_b), .wr_x(wr_x), .wr_y(wr_y), .wr_sp(wr_sp),
    .illegal(illegal), .cycles(cycles));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] opc, input logic [7:0] pb, input logic [7:0] rr,
      input logic [15:0] pc, input logic [7:0] a, input logic [7:0] b,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] s,
      output bit ill, output bit tk, output logic [15:0] cnt,
      output logic [15:0] npc, output logic [4:0] wr);
    int v, modn, off;
    bit isa, isb;
    ill = 0; v = 0; modn = 65536; isa = 0; isb = 0;
    case (pb[2:0])
      3'd0: begin v = a; modn = 256; isa = 1; end
      3'd1: begin v = b; modn = 256; isb = 1; end
      3'd4: begin v = a * 256 + b; isa = 1; isb = 1; end
      3'd5: v = x;
      3'd6: v = y;
      3'd7: v = s;
      default: ill = 1;
    endcase
    if (opc != 8'h04 || pb[7:6] == 2'b11) ill = 1;
    if (pb[7:6] == 2'b00) v = (v + modn - 1) % modn;
    if (pb[7:6] == 2'b10) v = (v + 1) % modn;
    tk = !ill && (pb[5] ? (v != 0) : (v == 0));
    off = pb[4] ? int'(rr) - 256 : int'(rr);
    npc = tk ? 16'(int'(pc) + 3 + off) : 16'(int'(pc) + 3);
    cnt = 16'(v);
    wr = '0;
    if (!ill && pb[7:6] != 2'b01) begin
      wr[4] = isa;
      wr[3] = isb;
      wr[2] = (pb[2:0] == 3'd5);
      wr[1] = (pb[2:0] == 3'd6);
      wr[0] = (pb[2:0] == 3'd7);
    end
  endfunction

  task automatic run_op(input logic [7:0] opc, input logic [7:0] pb, input logic [7:0] rr,
      input logic [15:0] pc, input logic [7:0] a, input logic [7:0] b,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] s);
    bit e_ill, e_tk;
    logic [15:0] e_cnt, e_npc;
    logic [4:0] e_wr;
    opcode = opc; postbyte = pb; offset_lo = rr; pc_in = pc;
    acc_a = a; acc_b = b; idx_x = x; idx_y = y; sp_in = s;
    in_valid = 1'b1;
    model(opc, pb, rr, pc, a, b, x, y, s, e_ill, e_tk, e_cnt, e_npc, e_wr);
    @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 32'd1);
    chk("R9 illegal", 32'(illegal), 32'(e_ill));
    chk("R4 taken", 32'(taken), 32'(e_tk));
    chk(e_tk ? "R2 next_pc" : "R3 next_pc", 32'(next_pc), 32'(e_npc));
    chk("R7 strobes", 32'({wr_a, wr_b, wr_x, wr_y, wr_sp}), 32'(e_wr));
    if (!e_ill) chk("R6 R8 cnt_value", 32'(cnt_value), 32'(e_cnt));
    chk("R10 cycles", 32'(cycles), 32'd3);
  endtask

  function automatic logic [15:0] edge16();
    case ($urandom % 5)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset next_pc", 32'(next_pc), 32'd0);
    chk("R1 reset strobes", 32'({wr_a, wr_b, wr_x, wr_y, wr_sp, taken, illegal}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: test A=0 with non-zero sense: no branch, no write
    run_op(8'h04, 8'h60, 8'h10, 16'h1000, 8'h00, 8'h55, 16'h1, 16'h2, 16'h3);
    // R5: test B non-zero, branch forward
    run_op(8'h04, 8'h61, 8'h20, 16'h1000, 8'h00, 8'h55, 16'h1, 16'h2, 16'h3);
    chk("R2 forward target", 32'(next_pc), 32'h1023);
    // R6 decrement A 1->0, branch on zero
    run_op(8'h04, 8'h00, 8'h05, 16'h2000, 8'h01, 8'h00, 16'h0, 16'h0, 16'h0);
    // R8 decrement A 0 -> FF wraps
    run_op(8'h04, 8'h20, 8'h05, 16'h2000, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);
    chk("R8 8-bit wrap", 32'(cnt_value), 32'h00FF);
    // R8 increment X FFFF -> 0
    run_op(8'h04, 8'h85, 8'h05, 16'h2000, 8'h00, 8'h00, 16'hFFFF, 16'h0, 16'h0);
    chk("R8 16-bit wrap", 32'(cnt_value), 32'h0000);
    // R8 decrement D 0x0100 -> 0x00FF, both halves written
    run_op(8'h04, 8'h24, 8'h00, 16'h3000, 8'h01, 8'h00, 16'h0, 16'h0, 16'h0);
    chk("R8 D pair strobes", 32'({wr_a, wr_b}), 32'b11);
    // R2 most negative offset, PC wrap low
    run_op(8'h04, 8'h77, 8'h00, 16'h0010, 8'h0, 8'h0, 16'h0, 16'h0, 16'h5);
    chk("R2 wrap below zero", 32'(next_pc), 32'hFF13);
    // R2 max positive offset, PC wrap high
    run_op(8'h04, 8'h67, 8'hFF, 16'hFFF0, 8'h0, 8'h0, 16'h0, 16'h0, 16'h5);
    chk("R2 wrap above top", 32'(next_pc), 32'h00F2);
    // R3 not-taken fall-through with wrap
    run_op(8'h04, 8'h66, 8'h40, 16'hFFFE, 8'h0, 8'h0, 16'h0, 16'h0, 16'h0);
    chk("R3 fall-through wrap", 32'(next_pc), 32'h0001);
    // R7 bit 3 ignored: same as 0x85
    run_op(8'h04, 8'h8D, 8'h05, 16'h2000, 8'h00, 8'h00, 16'h1234, 16'h0, 16'h0);
    chk("R7 bit3 ignored", 32'(cnt_value), 32'h1235);
    // R9 reserved codes
    run_op(8'h04, 8'h62, 8'h05, 16'h4000, 8'h1, 8'h1, 16'h1, 16'h1, 16'h1);
    run_op(8'h04, 8'h03, 8'h05, 16'h4000, 8'h1, 8'h1, 16'h1, 16'h1, 16'h1);
    run_op(8'h04, 8'hE5, 8'h05, 16'h4000, 8'h1, 8'h1, 16'h1, 16'h1, 16'h1);
    run_op(8'h05, 8'h65, 8'h05, 16'h4000, 8'h1, 8'h1, 16'h1, 16'h1, 16'h1);
    chk("R9 foreign opcode", 32'(illegal), 32'd1);

    // R1 idle cycle
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle quiet", 32'({out_valid, taken, illegal, wr_a, wr_b, wr_x, wr_y, wr_sp}), 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] opc, pb;
      opc = ($urandom % 8 == 0) ? 8'($urandom) : 8'h04;
      pb = 8'($urandom);
      run_op(opc, pb, 8'($urandom), edge16(), 8'(edge16()), 8'(edge16()),
             edge16(), edge16(), edge16());
      if (i % 50 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle quiet", 32'({out_valid, taken, wr_a, wr_b, wr_x, wr_y, wr_sp}), 32'd0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule